// File: doc/BRIEF.md
# Serial Converter Frame Capture Controller

This block sits on the host side of a 14-bit successive-approximation converter with a serial output. A one-cycle `start` request makes it launch a conversion. It drives the conversion strobe and, in the split-framing mode, a separate frame strobe. It counts rising edges of the serial clock, which arrives as a slow input derived from the same master clock. It shifts in one frame per conversion: an overrange flag, fourteen result bits with the most significant first, and a pad bit that should read zero.

The converter corrects errors internally, so the word a frame carries belongs to the sample taken one conversion earlier. The controller passes each word out with a one-cycle `word_valid` pulse. Alongside it, `word_good` goes low for the first word after reset, because that word has no real earlier sample behind it. A nonzero pad bit sets a sticky error flag. The static input `sep_frame` selects the framing mode. When it is low, the conversion strobe stays low for the whole frame and also frames the data. When it is high, the conversion strobe is a short pulse of `PULSE_CYC` master-clock cycles and the frame strobe frames the data. The idle level of the conversion strobe and a variant where the frame strobe is tied low are parameters.

Top module: `adc_serial_capture`

## Requirements
- R1: While `rst` is high and in the cycle after it: `cvt_strobe_n` is 1 (default idle-high variant), `word_valid` is 0 and `frame_err` is 0. `frm_strobe_n` is 0 when `sep_frame`=0 and 1 when `sep_frame`=1.
- R2: With `sep_frame`=0, a `start` seen while idle drives `cvt_strobe_n` low from the next cycle. It stays low until the 22nd serial-clock rising edge sampled in the frame, and returns high in the cycle after that edge. `frm_strobe_n` stays 0 throughout.
- R3: With `sep_frame`=1, a `start` seen while idle drives `cvt_strobe_n` low for exactly `PULSE_CYC` cycles (default 2). `frm_strobe_n` then goes low until the 22nd sampled serial-clock rising edge, while `cvt_strobe_n` stays high.
- R4: Within a frame, the input is sampled on serial-clock rising edges. The 1st sampled bit goes to `word_data[14]` (overrange). Bits 2 to 15 go to `word_data[13:0]`, most significant first. The 16th bit is the pad bit. Bits 17 to 22 are discarded.
- R5: `word_valid` is high for exactly one cycle, in the first cycle in which the framing strobe is inactive again after the 22nd edge. `word_data` holds the captured word from that cycle on.
- R6: `word_good` is 0 with the first word after reset and 1 with every later word.
- R7: A `start` that arrives while a conversion or frame is in progress is ignored. No second strobe follows the current frame.
- R8: A pad bit of 1 sets `frame_err`. It stays 1 through later clean frames until `rst`.
- R9: `sdata` values outside the framing window, and on serial-clock edges other than rising ones, have no effect on the captured word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| sep_frame | input | 1 | Static mode: 0 = conversion strobe frames data, 1 = separate frame strobe |
| start | input | 1 | Conversion request, one cycle |
| sclk | input | 1 | Serial clock derived from the master clock |
| sdata | input | 1 | Serial data from the converter |
| cvt_strobe_n | output | 1 | Conversion start strobe |
| frm_strobe_n | output | 1 | Frame strobe (held low when `sep_frame`=0) |
| word_valid | output | 1 | One-cycle pulse marking a new word |
| word_data | output | 15 | Bit 14 overrange, bits 13:0 result of the previous sample |
| word_good | output | 1 | Low for the first word after reset |
| frame_err | output | 1 | Sticky pad-bit error |

## Verification
The assertions check, on every cycle, that the valid pulse lasts one cycle and only ends a frame, that the error flag never clears without reset, that the strobe pulse counter stays within `PULSE_CYC`, that a frame in progress is not disturbed by a new request, and that the edge counter stays in range. Only the bench scenarios can show the bit order within a word, the one-word latency label, the exact strobe lengths in both framing modes, and that data outside the window is ignored. It does this by comparing the ports against a behavioural model on each clock while sending known frames with random data around them.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_STROBE = 2'd1,
      ST_FRAME  = 2'd2
   } cap_state_t;
endpackage

// File: rtl/adc_sclk_edge.sv
module adc_sclk_edge (
   input  logic clk,
   input  logic rst,
   input  logic sclk,
   output logic rise
);
   logic sclk_q;

   always_ff @(posedge clk) begin
      if (rst) sclk_q <= 1'b0;
      else     sclk_q <= sclk;
   end

   assign rise = sclk & ~sclk_q;
endmodule

// File: rtl/adc_frame_capture.sv
module adc_frame_capture #(
   parameter int FRAME_BITS   = 16,
   parameter int FRAME_PULSES = 22,
   localparam int CNT_W       = $clog2(FRAME_PULSES + 1)
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  clr,
   input  logic                  rise_en,
   input  logic                  sdata,
   output logic [FRAME_BITS-1:0] shreg,
   output logic                  done
);
   logic [CNT_W-1:0] cnt;

   generate
      if (FRAME_BITS > FRAME_PULSES) begin : g_bad_len
         $error("frame bits exceed serial pulses per frame");
      end
      if (FRAME_BITS < 3) begin : g_bad_bits
         $error("frame needs flag, data and pad bits");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         cnt   <= '0;
         shreg <= '0;
      end else if (rise_en) begin
         if (cnt < CNT_W'(FRAME_BITS))
            shreg <= {shreg[FRAME_BITS-2:0], sdata};
         cnt <= cnt + 1'b1;
      end
   end

   assign done = rise_en && (cnt == CNT_W'(FRAME_PULSES - 1));

   assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
      cnt <= CNT_W'(FRAME_PULSES));
endmodule

// File: rtl/adc_strobe_drive.sv
module adc_strobe_drive #(
   parameter bit IDLE_HIGH    = 1'b1,
   parameter bit TFS_TIED_LOW = 1'b0
) (
   input  logic sep_frame,
   input  logic in_strobe,
   input  logic in_frame,
   output logic cvt_strobe_n,
   output logic frm_strobe_n
);
   logic pulse_lvl;
   logic frm_lvl;

   generate
      if (IDLE_HIGH) begin : g_idle_hi
         assign pulse_lvl = ~in_strobe;
      end else begin : g_idle_lo
         assign pulse_lvl = in_strobe;
      end
      if (TFS_TIED_LOW) begin : g_frm_tied
         assign frm_lvl = 1'b0;
      end else begin : g_frm_drv
         assign frm_lvl = ~in_frame;
      end
   endgenerate

   assign cvt_strobe_n = sep_frame ? pulse_lvl : ~in_frame;
   assign frm_strobe_n = sep_frame ? frm_lvl : 1'b0;
endmodule

// File: rtl/adc_serial_capture.sv
module adc_serial_capture
   import adc_cap_pkg::*;
#(
   parameter int DATA_W       = 14,
   parameter int FRAME_PULSES = 22,
   parameter int PULSE_CYC    = 2,
   parameter bit IDLE_HIGH    = 1'b1,
   parameter bit TFS_TIED_LOW = 1'b0,
   localparam int WORD_W      = DATA_W + 1,
   localparam int FRAME_BITS  = DATA_W + 2,
   localparam int PC_W        = $clog2(PULSE_CYC + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sep_frame,
   input  logic              start,
   input  logic              sclk,
   input  logic              sdata,
   output logic              cvt_strobe_n,
   output logic              frm_strobe_n,
   output logic              word_valid,
   output logic [WORD_W-1:0] word_data,
   output logic              word_good,
   output logic              frame_err
);
   cap_state_t            state;
   logic [PC_W-1:0]       pcnt;
   logic                  primed;
   logic                  rise;
   logic                  rise_en;
   logic                  clr;
   logic                  frame_done;
   logic [FRAME_BITS-1:0] shreg;

   generate
      if (PULSE_CYC < 1) begin : g_bad_pulse
         $error("strobe pulse must last at least one cycle");
      end
      if (IDLE_HIGH && PULSE_CYC > 2) begin : g_bad_hi_pulse
         $error("idle-high strobe pulse may not exceed two cycles");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("data width must be positive");
      end
   endgenerate

   adc_sclk_edge u_edge (
      .clk  (clk),
      .rst  (rst),
      .sclk (sclk),
      .rise (rise)
   );

   assign rise_en = rise && (state == ST_FRAME);
   assign clr     = (state == ST_IDLE) && start;

   adc_frame_capture #(
      .FRAME_BITS   (FRAME_BITS),
      .FRAME_PULSES (FRAME_PULSES)
   ) u_cap (
      .clk     (clk),
      .rst     (rst),
      .clr     (clr),
      .rise_en (rise_en),
      .sdata   (sdata),
      .shreg   (shreg),
      .done    (frame_done)
   );

   adc_strobe_drive #(
      .IDLE_HIGH    (IDLE_HIGH),
      .TFS_TIED_LOW (TFS_TIED_LOW)
   ) u_drv (
      .sep_frame    (sep_frame),
      .in_strobe    (state == ST_STROBE),
      .in_frame     (state == ST_FRAME),
      .cvt_strobe_n (cvt_strobe_n),
      .frm_strobe_n (frm_strobe_n)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state      <= ST_IDLE;
         pcnt       <= '0;
         primed     <= 1'b0;
         word_valid <= 1'b0;
         word_data  <= '0;
         word_good  <= 1'b0;
         frame_err  <= 1'b0;
      end else begin
         word_valid <= 1'b0;
         case (state)
            ST_IDLE: begin
               pcnt <= '0;
               if (start) state <= sep_frame ? ST_STROBE : ST_FRAME;
            end
            ST_STROBE: begin
               if (pcnt == PC_W'(PULSE_CYC - 1)) state <= ST_FRAME;
               else                              pcnt  <= pcnt + 1'b1;
            end
            ST_FRAME: begin
               if (frame_done) begin
                  state      <= ST_IDLE;
                  word_valid <= 1'b1;
                  word_data  <= shreg[FRAME_BITS-1:1];
                  word_good  <= primed;
                  primed     <= 1'b1;
                  if (shreg[0]) frame_err <= 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (rst)
      word_valid |=> !word_valid);
   assert_valid_after_frame_R5: assert property (@(posedge clk) disable iff (rst)
      word_valid |-> $past(state == ST_FRAME));
   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
      frame_err |=> frame_err);
   assert_strobe_len_R3: assert property (@(posedge clk) disable iff (rst)
      (state == ST_STROBE) |-> (pcnt < PC_W'(PULSE_CYC)));
   assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
      (state == ST_FRAME && start && !frame_done) |=> (state == ST_FRAME));
endmodule

// File: tb/tb_adc_serial_capture.sv
`timescale 1ns/1ps
module tb_adc_serial_capture;
   localparam int PULSE_CYC = 2;
   localparam int NPULSE    = 22;

   logic        clk = 1'b0;
   logic        rst, sep_frame, start, sclk, sdata;
   logic        cvt_strobe_n, frm_strobe_n, word_valid, word_good, frame_err;
   logic [14:0] word_data;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   adc_serial_capture #(.PULSE_CYC(PULSE_CYC)) dut (
      .clk(clk), .rst(rst), .sep_frame(sep_frame), .start(start),
      .sclk(sclk), .sdata(sdata), .cvt_strobe_n(cvt_strobe_n),
      .frm_strobe_n(frm_strobe_n), .word_valid(word_valid),
      .word_data(word_data), .word_good(word_good), .frame_err(frame_err)
   );

   // behavioural reference model
   int       m_state = 0;  // 0 idle, 1 strobe, 2 frame
   int       m_cnt = 0, m_pcnt = 0;
   bit       m_prev = 0, m_valid = 0, m_good = 0, m_primed = 0, m_err = 0;
   bit [14:0] m_word = 0;
   bit       m_bits[$];

   always @(posedge clk) begin
      if (rst) begin
         m_state = 0; m_cnt = 0; m_pcnt = 0; m_prev = 0; m_valid = 0;
         m_good = 0; m_primed = 0; m_err = 0; m_word = 0; m_bits.delete();
      end else begin
         bit r;
         r = sclk && !m_prev;
         m_valid = 0;
         if (m_state == 0) begin
            if (start) begin
               m_state = sep_frame ? 1 : 2;
               m_pcnt = 0; m_cnt = 0; m_bits.delete();
            end
         end else if (m_state == 1) begin
            if (m_pcnt == PULSE_CYC - 1) m_state = 2;
            else m_pcnt++;
         end else if (r) begin
            if (m_cnt < 16) m_bits.push_back(sdata);
            if (m_cnt == NPULSE - 1) begin
               for (int i = 0; i < 15; i++) m_word[14-i] = m_bits[i];
               if (m_bits[15]) m_err = 1;
               m_valid = 1; m_good = m_primed; m_primed = 1; m_state = 0;
            end
            m_cnt++;
         end
         m_prev = sclk;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   bit          armed = 0;
   bit          got_valid = 0;
   int          words_since_rst = 0;
   int          sdiv = 0, nrise = 0;
   bit [15:0]   tx_cur = 0;
   bit [15:0]   exp_q[$];

   task automatic compare_all();
      bit ecv, efr;
      ecv = sep_frame ? !(m_state == 1) : !(m_state == 2);
      efr = sep_frame ? !(m_state == 2) : 1'b0;
      chk(cvt_strobe_n === ecv, "R2 R3 R7", "cvt_strobe_n", cvt_strobe_n, ecv);
      chk(frm_strobe_n === efr, "R2 R3", "frm_strobe_n", frm_strobe_n, efr);
      chk(word_valid === m_valid, "R5", "word_valid", word_valid, m_valid);
      chk(frame_err === m_err, "R8", "frame_err", frame_err, m_err);
      if (m_valid) begin
         chk(word_data === m_word, "R4 R9", "word_data vs model", word_data, m_word);
         chk(word_good === m_good, "R6", "word_good vs model", word_good, m_good);
      end
      if (word_valid === 1'b1) begin
         bit [15:0] e;
         got_valid = 1;
         e = (exp_q.size() > 0) ? exp_q.pop_front() : 16'h0;
         // R4 R9: word equals the transmitted frame without its pad bit
         chk(word_data === e[15:1], "R4 R9", "word_data vs sent", word_data, e[15:1]);
         // R6: first word after reset is labelled stale
         chk(word_good === (words_since_rst > 0), "R6", "word_good", word_good,
             words_since_rst > 0);
         words_since_rst++;
      end
   endtask

   task automatic tick();
      @(negedge clk);
      if (armed) compare_all();
      sdiv++;
      if (sdiv == 2) begin
         sdiv = 0;
         if (!sclk) begin
            bit win;
            win = sep_frame ? !frm_strobe_n : !cvt_strobe_n;
            if (win) begin
               sdata = (nrise < 16) ? tx_cur[15-nrise] : 1'($urandom % 2);
               nrise++;
            end else begin
               sdata = 1'($urandom % 2);
            end
            sclk = 1;
         end else begin
            sclk = 0;
         end
      end
   endtask

   task automatic do_frame(input bit [15:0] tx, input bit interrupt);
      tick();
      exp_q.push_back(tx);
      tx_cur = tx; nrise = 0; got_valid = 0;
      start = 1;
      tick();
      start = 0;
      for (int i = 0; i < 400 && !got_valid; i++) begin
         tick();
         if (interrupt && (i == 20 || i == 60)) start = 1;
         else start = 0;
      end
      start = 0;
      if (!got_valid) chk(0, "R5", "no word produced", 0, 1);
      for (int i = 0; i < 6; i++) begin
         tick();
         // R7: no further strobe after an ignored request
         if (interrupt)
            chk(cvt_strobe_n === 1'b1 && (sep_frame ? frm_strobe_n === 1'b1 : 1'b1),
                "R7", "strobe after frame", cvt_strobe_n, 1);
      end
   endtask

   task automatic do_reset(input bit mode);
      rst = 1; sep_frame = mode; start = 0;
      exp_q.delete(); words_since_rst = 0;
      tick(); tick();
      chk(cvt_strobe_n === 1'b1, "R1", "reset cvt_strobe_n", cvt_strobe_n, 1);
      chk(frm_strobe_n === mode, "R1", "reset frm_strobe_n", frm_strobe_n, mode);
      chk(word_valid === 1'b0, "R1", "reset word_valid", word_valid, 0);
      chk(frame_err === 1'b0, "R1 R8", "reset frame_err", frame_err, 0);
      rst = 0;
      tick();
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst = 1; sep_frame = 0; start = 0; sclk = 0; sdata = 0;
      armed = 1;
      // mode with conversion strobe framing the data (R2)
      do_reset(1'b0);
      do_frame(16'hA5A4, 1'b0);
      do_frame(16'h7FFE, 1'b0);
      do_frame(16'h8002, 1'b1);   // R7 requests during frame
      do_frame(16'h1235, 1'b0);   // R8 pad bit set
      chk(frame_err === 1'b1, "R8", "err after bad pad", frame_err, 1);
      do_frame(16'h4C3A, 1'b0);
      chk(frame_err === 1'b1, "R8", "err sticky", frame_err, 1);
      // separate frame strobe mode (R3)
      do_reset(1'b1);
      do_frame(16'hFFFE, 1'b0);
      do_frame(16'h0000, 1'b1);
      do_frame(16'h5A5A, 1'b0);
      do_frame(16'h2469, 1'b0);
      chk(frame_err === 1'b1, "R8", "err in split mode", frame_err, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule